// File: doc/BRIEF.md
# Split Serial Access Register

This block is the serial read-out side of a dual-ported video memory. A whole memory row is copied in one cycle into a wide register. A serial clock then streams that register out one word per step, turning the parallel array data into a serial pixel stream. The register can also be handled as two halves. While one half is still being shifted out, the system can reload the other half from a new row, so the serial stream never has to stop for a transfer.

The memory array is outside this block. A behavioural row source stands in for it: it gives every word of a selected row a known value. Two kinds of transfer are supported:

- A full transfer reloads every word and restarts the serial pointer at a chosen tap.
- A split transfer reloads one half only and leaves the pointer where it is.

In split operation, a flag per half tells the system which half has been fully read and may be refilled. An error flag reports any attempt to reload the half that is being read.

Top module: `split_serial_reg`

## Requirements
- R1: While reset is high and after it is released, `sout` is 0, `cur_tap` is 0, `half_free` is 00, `xfer_err` is 0 and `split_mode` is 0.
- R2: A transfer with `xfer_split`=0 loads all DEPTH words from row `xfer_row` and sets `cur_tap` to `xfer_tap` on the same clock edge. The word at column c of row r is {r[7:0], c[7:0]}, with the row in bits 15:8 and the column in bits 7:0.
- R3: On each clock edge where `sclk_step` is 1, `sout` takes the word at `cur_tap` and `cur_tap` increments by one. On edges without a step, `sout` holds its value.
- R4: While the last accepted transfer was a full one, the pointer wraps from DEPTH-1 to 0 and `half_free` stays 00.
- R5: An accepted split transfer (`xfer_split`=1) loads only the half named by `xfer_half` (0 = columns 0..DEPTH/2-1, 1 = the upper columns). The other half keeps its contents, and the pointer is not moved.
- R6: In split mode, a step that leaves column DEPTH/2-1 or DEPTH-1 moves the pointer to the start of the other half. The same step sets `half_free` bit 0 or bit 1 respectively, for the half just left.
- R7: A split transfer naming the half that contains `cur_tap` is rejected: no word changes, and `xfer_err` becomes 1. `xfer_err` returns to 0 on the next accepted transfer.
- R8: An accepted split transfer clears the `half_free` bit of the half it loads. An accepted full transfer clears both bits.
- R9: When a full transfer and a step arrive on the same edge, the transfer wins. The step is dropped, and `sout` keeps its value.
- R10: `split_mode` is 1 after an accepted split transfer and 0 after a full transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_stb | input | 1 | Transfer strobe, one cycle |
| xfer_split | input | 1 | 1 = half transfer, 0 = whole-register transfer |
| xfer_half | input | 1 | Half to load for a split transfer |
| xfer_row | input | ROW_W | Row supplying the data |
| xfer_tap | input | log2(DEPTH) | Start column for a full transfer |
| sclk_step | input | 1 | Serial clock step, one word per cycle high |
| sout | output | WIDTH | Serial data word |
| cur_tap | output | log2(DEPTH) | Column the next step will output |
| split_mode | output | 1 | Split operation active |
| half_free | output | 2 | Per-half "read out, may reload" flags |
| xfer_err | output | 1 | Last transfer attempt was rejected |

## Verification
Every result of this block appears on the clock edge that samples its stimulus: the transfer's effect on `cur_tap`, `split_mode`, `half_free` and `xfer_err`, the stepped word on `sout`, and a set free flag on a crossing step. The bench drives each stimulus on the falling edge and samples 1 ns after the next rising edge. Expected values therefore always refer to exactly one edge. Checks that something is unaffected, such as the untouched half or a rejected transfer, are made by stepping the affected columns out afterwards and comparing against the row that should still be there.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int unsigned SSR_DEPTH = 256;
    localparam int unsigned SSR_WIDTH = 16;
    localparam int unsigned SSR_ROW_W = 8;

    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_SPLIT = 1'b1
    } ssr_mode_e;

    typedef struct packed {
        logic stb;
        logic split;
        logic half;
    } ssr_req_t;

    function automatic logic [63:0] row_word(input logic [31:0] row,
                                             input logic [31:0] col,
                                             input int unsigned col_w);
        return ({32'd0, row} << col_w) | {32'd0, col};
    endfunction

endpackage

// File: rtl/ssr_row_source.sv
module ssr_row_source
    import ssr_pkg::*;
#(
    parameter int unsigned DEPTH = SSR_DEPTH,
    parameter int unsigned WIDTH = SSR_WIDTH,
    parameter int unsigned ROW_W = SSR_ROW_W
) (
    input  logic [ROW_W-1:0]              row,
    output logic [DEPTH-1:0][WIDTH-1:0]   words
);
    localparam int unsigned COL_W = $clog2(DEPTH);

    for (genvar c = 0; c < DEPTH; c++) begin : g_col
        logic [63:0] full_word;
        assign full_word = row_word(32'(row), 32'(c), COL_W);
        assign words[c]  = full_word[WIDTH-1:0];
    end

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
    import ssr_pkg::*;
#(
    parameter int unsigned DEPTH = SSR_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ssr_req_t                   req,
    input  logic [$clog2(DEPTH)-1:0]   tap_in,
    input  logic                       step,
    output logic [$clog2(DEPTH)-1:0]   ptr_o,
    output logic                       step_en_o,
    output logic                       load_lo_o,
    output logic                       load_hi_o,
    output ssr_mode_e                  mode_o,
    output logic [1:0]                 free_o,
    output logic                       err_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned HALF  = DEPTH / 2;

    logic [PTR_W-1:0] ptr_q, ptr_nxt;
    ssr_mode_e        mode_q, mode_nxt;
    logic [1:0]       free_q, free_nxt;
    logic             err_q, err_nxt;

    logic accept_full, split_hit, reject, accept_split, step_en, at_half_end;

    always_comb begin
        accept_full  = req.stb && !req.split;
        split_hit    = req.stb && req.split;
        reject       = split_hit && (req.half == ptr_q[PTR_W-1]);
        accept_split = split_hit && !reject;
        step_en      = step && !accept_full;
        at_half_end  = &ptr_q[PTR_W-2:0];
    end

    always_comb begin
        ptr_nxt = ptr_q;
        if (accept_full)  ptr_nxt = tap_in;
        else if (step_en) ptr_nxt = ptr_q + 1'b1;

        mode_nxt = mode_q;
        if (accept_full)       mode_nxt = MODE_FULL;
        else if (accept_split) mode_nxt = MODE_SPLIT;

        free_nxt = free_q;
        if (accept_full) begin
            free_nxt = 2'b00;
        end else begin
            if (accept_split) free_nxt[req.half] = 1'b0;
            if (mode_nxt == MODE_SPLIT && step_en && at_half_end)
                free_nxt[ptr_q[PTR_W-1]] = 1'b1;
        end

        err_nxt = err_q;
        if (accept_full || accept_split) err_nxt = 1'b0;
        else if (reject)                 err_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            mode_q <= MODE_FULL;
            free_q <= 2'b00;
            err_q  <= 1'b0;
        end else begin
            ptr_q  <= ptr_nxt;
            mode_q <= mode_nxt;
            free_q <= free_nxt;
            err_q  <= err_nxt;
        end
    end

    assign ptr_o     = ptr_q;
    assign step_en_o = step_en;
    assign load_lo_o = accept_full || (accept_split && !req.half);
    assign load_hi_o = accept_full || (accept_split && req.half);
    assign mode_o    = mode_q;
    assign free_o    = free_q;
    assign err_o     = err_q;

    assert_tap_load_R2: assert property (@(posedge clk) disable iff (rst)
        (req.stb && !req.split) |=> (ptr_q == $past(tap_in)));

    assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !(req.stb && !req.split)) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

    assert_full_no_free_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FULL) |-> (free_q == 2'b00));

    assert_cross_sets_free_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SPLIT && !req.stb && step && ptr_q == PTR_W'(HALF - 1)) |=> free_q[0]);

    assert_reject_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (req.stb && req.split && req.half == ptr_q[PTR_W-1]) |=> err_q);

endmodule

// File: rtl/ssr_store.sv
module ssr_store
    import ssr_pkg::*;
#(
    parameter int unsigned DEPTH = SSR_DEPTH,
    parameter int unsigned WIDTH = SSR_WIDTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DEPTH-1:0][WIDTH-1:0]   src,
    input  logic                          load_lo,
    input  logic                          load_hi,
    input  logic                          step_en,
    input  logic [$clog2(DEPTH)-1:0]      ptr,
    output logic [WIDTH-1:0]              sout
);
    localparam int unsigned HALF = DEPTH / 2;

    logic [WIDTH-1:0] words_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam bit UPPER = (i >= HALF);
        logic load_me;
        assign load_me = UPPER ? load_hi : load_lo;
        always_ff @(posedge clk) begin
            if (rst)          words_q[i] <= '0;
            else if (load_me) words_q[i] <= src[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          sout <= '0;
        else if (step_en) sout <= words_q[ptr];
    end

    assert_hold_sout_R3: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(sout));

    assert_half_untouched_R5: assert property (@(posedge clk) disable iff (rst)
        (load_lo && !load_hi) |=> $stable(words_q[DEPTH-1]));

endmodule

// File: rtl/split_serial_reg.sv
module split_serial_reg
    import ssr_pkg::*;
#(
    parameter int unsigned DEPTH = SSR_DEPTH,
    parameter int unsigned WIDTH = SSR_WIDTH,
    parameter int unsigned ROW_W = SSR_ROW_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       xfer_stb,
    input  logic                       xfer_split,
    input  logic                       xfer_half,
    input  logic [ROW_W-1:0]           xfer_row,
    input  logic [$clog2(DEPTH)-1:0]   xfer_tap,
    input  logic                       sclk_step,
    output logic [WIDTH-1:0]           sout,
    output logic [$clog2(DEPTH)-1:0]   cur_tap,
    output logic                       split_mode,
    output logic [1:0]                 half_free,
    output logic                       xfer_err
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    ssr_req_t                  req;
    logic [DEPTH-1:0][WIDTH-1:0] row_words;
    logic [PTR_W-1:0]          ptr;
    logic                      step_en, load_lo, load_hi;
    ssr_mode_e                 mode;

    assign req = '{stb: xfer_stb, split: xfer_split, half: xfer_half};

    ssr_row_source #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ROW_W(ROW_W)) u_src (
        .row   (xfer_row),
        .words (row_words)
    );

    ssr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .tap_in    (xfer_tap),
        .step      (sclk_step),
        .ptr_o     (ptr),
        .step_en_o (step_en),
        .load_lo_o (load_lo),
        .load_hi_o (load_hi),
        .mode_o    (mode),
        .free_o    (half_free),
        .err_o     (xfer_err)
    );

    ssr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .src     (row_words),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .step_en (step_en),
        .ptr     (ptr),
        .sout    (sout)
    );

    assign cur_tap    = ptr;
    assign split_mode = (mode == MODE_SPLIT);

    assert_err_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && !xfer_split) |=> !xfer_err);

    assert_mode_full_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && !xfer_split) |=> !split_mode);

endmodule

// File: tb/split_serial_reg_bench.sv
module split_serial_reg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_stb = 1'b0, xfer_split = 1'b0, xfer_half = 1'b0;
    logic [7:0]  xfer_row = '0;
    logic [7:0]  xfer_tap = '0;
    logic        sclk_step = 1'b0;
    logic [15:0] sout;
    logic [7:0]  cur_tap;
    logic        split_mode;
    logic [1:0]  half_free;
    logic        xfer_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    split_serial_reg u_split_serial_reg (
        .clk, .rst, .xfer_stb, .xfer_split, .xfer_half, .xfer_row, .xfer_tap,
        .sclk_step, .sout, .cur_tap, .split_mode, .half_free, .xfer_err
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic tick(input logic stb, input logic split, input logic half,
                        input logic [7:0] row, input logic [7:0] tap, input logic step);
        @(negedge clk);
        xfer_stb = stb; xfer_split = split; xfer_half = half;
        xfer_row = row; xfer_tap = tap; sclk_step = step;
        @(posedge clk);
        #1;
        xfer_stb = 1'b0; sclk_step = 1'b0;
    endtask

    task automatic step_expect(input string req, input logic [7:0] row, input logic [7:0] col);
        tick(0, 0, 0, 8'h00, 8'h00, 1);
        chk(req, 32'(sout), 32'({row, col}));
    endtask

    task automatic t_reset;
        chk("R1 sout", 32'(sout), 0);
        chk("R1 tap", 32'(cur_tap), 0);
        chk("R1 free", 32'(half_free), 0);
        chk("R1 err", 32'(xfer_err), 0);
        chk("R1 mode", 32'(split_mode), 0);
    endtask

    task automatic t_full_load;
        tick(1, 0, 0, 8'h3C, 8'd5, 0);
        chk("R2 tap set", 32'(cur_tap), 5);
        step_expect("R2 R3 first word", 8'h3C, 8'd5);
        step_expect("R3 second word", 8'h3C, 8'd6);
        step_expect("R3 third word", 8'h3C, 8'd7);
        chk("R3 tap advanced", 32'(cur_tap), 8);
        tick(0, 0, 0, 8'h00, 8'h00, 0);
        chk("R3 hold", 32'(sout), 32'h3C07);
    endtask

    task automatic t_full_wrap;
        tick(1, 0, 0, 8'h11, 8'd254, 0);
        step_expect("R4 col 254", 8'h11, 8'd254);
        step_expect("R4 col 255", 8'h11, 8'd255);
        step_expect("R4 wrap col 0", 8'h11, 8'd0);
        chk("R4 no free", 32'(half_free), 0);
        chk("R10 full mode", 32'(split_mode), 0);
    endtask

    task automatic t_split;
        tick(1, 0, 0, 8'h20, 8'd0, 0);
        tick(1, 1, 1, 8'h21, 8'd0, 0);
        chk("R10 split mode", 32'(split_mode), 1);
        chk("R7 accepted no err", 32'(xfer_err), 0);
        chk("R5 ptr unmoved", 32'(cur_tap), 0);
        for (int c = 0; c < 128; c++) step_expect("R5 lower half kept", 8'h20, 8'(c));
        chk("R6 free lower", 32'(half_free), 32'b01);
        chk("R6 crossed", 32'(cur_tap), 128);
        tick(1, 1, 1, 8'h22, 8'd0, 0);
        chk("R7 reject err", 32'(xfer_err), 1);
        chk("R7 free unchanged", 32'(half_free), 32'b01);
        step_expect("R7 data unchanged", 8'h21, 8'd128);
        tick(1, 1, 0, 8'h22, 8'd0, 0);
        chk("R7 err cleared", 32'(xfer_err), 0);
        chk("R8 free cleared", 32'(half_free), 0);
        for (int c = 129; c < 256; c++) step_expect("R5 upper half loaded", 8'h21, 8'(c));
        chk("R6 free upper", 32'(half_free), 32'b10);
        step_expect("R6 wrap to lower", 8'h22, 8'd0);
    endtask

    task automatic t_collide;
        tick(1, 0, 0, 8'h40, 8'd10, 1);
        chk("R9 tap wins", 32'(cur_tap), 10);
        chk("R9 sout kept", 32'(sout), 32'h2200);
        chk("R8 full clears free", 32'(half_free), 0);
        chk("R10 back to full", 32'(split_mode), 0);
        step_expect("R2 new row", 8'h40, 8'd10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_full_load();
        t_full_wrap();
        t_split();
        t_collide();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule